// File: doc/BRIEF.md
# Triplicated Output Voter with Per-Domain Tristate Release

This block sends one logical output word of a triplicated design to the outside world through three pad drivers whose outputs are tied to the same pin. The vote is formed on the shared wire and not in a single voting gate. Each of the three redundant domains first registers its own copy of the word. For every bit, a small disagreement detector then compares that domain's copy with the copies of the other two domains. A domain whose bit stands alone against the other two releases its driver for that bit to high impedance. Only the agreeing majority is then left driving the net.

The outputs are the three data/release pairs that feed the tristate pad drivers, and a behavioural model of the value that appears on the shared net. A per-domain minority flag reports whether any bit of that domain was released in the current cycle, so that a fault counter elsewhere can tally upsets. A fault in one domain is masked at the pin. Faults in two domains on the same bit take the pin to the faulty value.

Top module: `tmrpad_vote_out`

## Requirements
- R1: While `rst_n` is low at a rising edge, every domain register clears, so after that edge `drv_data`, `drv_hiz`, `pad_val` and `minority` are all zero.
- R2: `drv_data[d]` equals `dom_val[d]` as sampled at the previous rising edge at which `rst_n` was high (one register stage per domain).
- R3: `drv_hiz[d][b]` is 1 (driver released) exactly when registered bit b of domain d differs from that bit in both other domains. For domain 0, with its own bit as the most significant of the pattern (d0,d1,d2), the release function over patterns 000..111 is 0,0,0,1,1,0,0,0: only 011 and 100 release it. Domains 1 and 2 use the same rule with their own bit as the reference.
- R4: When all three registered domain words are equal, no driver is released (`drv_hiz` all zero).
- R5: With a fault confined to one domain, `pad_val` equals the word held by the other two domains.
- R6: On every bit, any two drivers that are both enabled carry the same data value (no contention on the shared net).
- R7: `pad_val` equals the bitwise majority of the three registered words. When two domains hold the same wrong bit, the pin shows that wrong bit.
- R8: `minority[d]` is 1 exactly when at least one bit of `drv_hiz[d]` is 1.
- R9: On every bit, at most one of the three drivers is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the domain output registers |
| rst_n | input | 1 | Synchronous active-low reset |
| dom_val | input | 3 x W | Word from each redundant domain, index = domain |
| drv_data | output | 3 x W | Registered data presented to each domain's pad driver |
| drv_hiz | output | 3 x W | Per-bit release of each driver, 1 = high impedance |
| pad_val | output | W | Modelled resolved value of the shared pad net |
| minority | output | 3 | Domain had at least one bit released this cycle |

## Verification
The hardest situation to reach is a bit where two domains both hold the wrong value, because random words from independent domains produce it only by chance and say nothing about which domain stood alone. The stimulus therefore includes one fixed set of three words whose bit columns walk through all eight domain patterns at once. It also injects double faults on purpose by copying one flipped bit mask into two domains. A behavioural model then shows that the pin follows the faulty pair while the release falls on the only correct domain.

// File: rtl/tmrpad_pkg.sv
// Shared constants and helpers for the triplicated pad voter.
// Assumes exactly three redundant domains; helpers return peer indices.
package tmrpad_pkg;

    localparam int unsigned NDOM = 3;

    // Index of the k-th peer of domain d, wrapping around the domain ring.
    function automatic int unsigned peer_idx(input int unsigned d, input int unsigned k);
        return (d + k) % NDOM;
    endfunction

endpackage

// File: rtl/tmrpad_dom_reg.sv
// One domain's output register in front of its pad driver.
// Assumes a synchronous active-low reset that clears the word to zero.
module tmrpad_dom_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture the domain word each cycle, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/tmrpad_minority.sv
// Disagreement detector for one domain: per bit, releases the domain's
// driver when its bit differs from both peers. Purely combinational;
// assumes the three inputs come from matching register stages.
module tmrpad_minority #(
    parameter int unsigned W    = 8,
    parameter int unsigned SELF = 0
) (
    input  logic [tmrpad_pkg::NDOM-1:0][W-1:0] vals,
    output logic [W-1:0]                       hiz
);
    import tmrpad_pkg::*;

    localparam int unsigned PA = peer_idx(SELF, 1);
    localparam int unsigned PB = peer_idx(SELF, 2);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic own_b;
        logic pa_b;
        logic pb_b;
        assign own_b = vals[SELF][b];
        assign pa_b  = vals[PA][b];
        assign pb_b  = vals[PB][b];
        // Release only when both peers hold the opposite value.
        always_comb hiz[b] = (own_b != pa_b) && (own_b != pb_b);
    end

endmodule

// File: rtl/tmrpad_net_model.sv
// Behavioural resolution of the shared pad net: a bit reads 1 when an
// enabled driver pushes 1, else 0. Assumes enabled drivers agree
// (contention is excluded by the minority logic and checked elsewhere).
module tmrpad_net_model #(
    parameter int unsigned W = 8
) (
    input  logic [tmrpad_pkg::NDOM-1:0][W-1:0] data,
    input  logic [tmrpad_pkg::NDOM-1:0][W-1:0] hiz,
    output logic [W-1:0]                       net
);
    import tmrpad_pkg::*;

    // Wired-OR of the data from every enabled driver.
    always_comb begin
        net = '0;
        for (int unsigned d = 0; d < NDOM; d++) begin
            net = net | (data[d] & ~hiz[d]);
        end
    end

endmodule

// File: rtl/tmrpad_vote_out.sv
// Triplicated output voter using the pin as the voting point.
// Each domain registers its word, releases its own driver on bits where
// it is the lone dissenter, and a model of the shared net gives pad_val.
// Assumes all three domains share clk and rst_n.
module tmrpad_vote_out #(
    parameter int unsigned W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [tmrpad_pkg::NDOM-1:0][W-1:0] dom_val,
    output logic [tmrpad_pkg::NDOM-1:0][W-1:0] drv_data,
    output logic [tmrpad_pkg::NDOM-1:0][W-1:0] drv_hiz,
    output logic [W-1:0]                       pad_val,
    output logic [tmrpad_pkg::NDOM-1:0]        minority
);
    import tmrpad_pkg::*;

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        tmrpad_dom_reg #(.W(W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (dom_val[d]),
            .q     (drv_data[d])
        );

        tmrpad_minority #(.W(W), .SELF(d)) u_min (
            .vals (drv_data),
            .hiz  (drv_hiz[d])
        );

        // Flag a domain that lost the vote on any bit this cycle.
        always_comb minority[d] = |drv_hiz[d];
    end

    tmrpad_net_model #(.W(W)) u_net (
        .data (drv_data),
        .hiz  (drv_hiz),
        .net  (pad_val)
    );

endmodule

// File: rtl/tmrpad_vote_out_chk.sv
// Property checker for tmrpad_vote_out, attached by bind.
module tmrpad_vote_out_chk #(
    parameter int unsigned W = 8
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic [tmrpad_pkg::NDOM-1:0][W-1:0] dom_val,
    input logic [tmrpad_pkg::NDOM-1:0][W-1:0] drv_data,
    input logic [tmrpad_pkg::NDOM-1:0][W-1:0] drv_hiz,
    input logic [W-1:0]                       pad_val,
    input logic [tmrpad_pkg::NDOM-1:0]        minority
);

    // R2
    reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (drv_data == $past(dom_val)));

    // R4
    agree_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_data[0] == drv_data[1]) && (drv_data[1] == drv_data[2])) |-> (drv_hiz == '0));

    // R6
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((~drv_hiz[0] & ~drv_hiz[1] & (drv_data[0] ^ drv_data[1])) |
          (~drv_hiz[0] & ~drv_hiz[2] & (drv_data[0] ^ drv_data[2])) |
          (~drv_hiz[1] & ~drv_hiz[2] & (drv_data[1] ^ drv_data[2]))) == '0));

    // R9
    single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((drv_hiz[0] & drv_hiz[1]) | (drv_hiz[0] & drv_hiz[2]) |
          (drv_hiz[1] & drv_hiz[2])) == '0));

    // R7
    pad_follows_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((~drv_hiz[0] & (pad_val ^ drv_data[0])) |
          (~drv_hiz[1] & (pad_val ^ drv_data[1])) |
          (~drv_hiz[2] & (pad_val ^ drv_data[2]))) == '0));

    // R8
    minority_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        minority == {|drv_hiz[2], |drv_hiz[1], |drv_hiz[0]});

endmodule

bind tmrpad_vote_out tmrpad_vote_out_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dom_val  (dom_val),
    .drv_data (drv_data),
    .drv_hiz  (drv_hiz),
    .pad_val  (pad_val),
    .minority (minority)
);

// File: tb/test_tmrpad_vote_out.sv
module test_tmrpad_vote_out;
    localparam int unsigned W = 8;
    localparam time CLK_PERIOD = 10ns;
    localparam int unsigned MAX_CYC = 20000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [2:0][W-1:0]    dom_val = '0;
    logic [2:0][W-1:0]    drv_data;
    logic [2:0][W-1:0]    drv_hiz;
    logic [W-1:0]         pad_val;
    logic [2:0]           minority;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    tmrpad_vote_out #(.W(W)) i_tmrpad_vote_out (
        .clk(clk), .rst_n(rst_n), .dom_val(dom_val),
        .drv_data(drv_data), .drv_hiz(drv_hiz),
        .pad_val(pad_val), .minority(minority)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: a one-deep queue of captured words.
    logic [W-1:0] ref_q [$];
    initial begin
        for (int d = 0; d < 3; d++) ref_q.push_back('0);
    end
    always @(posedge clk) begin
        for (int d = 0; d < 3; d++) begin
            void'(ref_q.pop_front());
            ref_q.push_back(rst_n ? dom_val[d] : '0);
        end
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare every output with the model away from the clock edge.
    always @(negedge clk) begin
        if (!finished) begin
            for (int d = 0; d < 3; d++) begin
                logic [W-1:0] e_hiz;
                e_hiz = '0;
                for (int b = 0; b < W; b++) begin
                    int ones;
                    ones = ref_q[0][b] + ref_q[1][b] + ref_q[2][b];
                    if (ref_q[d][b] ? (ones == 1) : (ones == 2)) e_hiz[b] = 1'b1;
                end
                check("R2 drv_data", drv_data[d], ref_q[d]);
                check("R3 drv_hiz", drv_hiz[d], e_hiz);
                check("R8 minority", {{(W-1){1'b0}}, minority[d]}, {{(W-1){1'b0}}, |e_hiz});
            end
            begin
                logic [W-1:0] e_pad;
                logic [W-1:0] clash;
                logic [W-1:0] twice;
                for (int b = 0; b < W; b++)
                    e_pad[b] = (ref_q[0][b] + ref_q[1][b] + ref_q[2][b]) >= 2;
                check("R7 pad_val", pad_val, e_pad);
                clash = (~drv_hiz[0] & ~drv_hiz[1] & (drv_data[0] ^ drv_data[1])) |
                        (~drv_hiz[0] & ~drv_hiz[2] & (drv_data[0] ^ drv_data[2])) |
                        (~drv_hiz[1] & ~drv_hiz[2] & (drv_data[1] ^ drv_data[2]));
                check("R6 contention", clash, '0);
                twice = (drv_hiz[0] & drv_hiz[1]) | (drv_hiz[0] & drv_hiz[2]) |
                        (drv_hiz[1] & drv_hiz[2]);
                check("R9 double release", twice, '0);
            end
        end
    end

    task automatic put(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
        @(posedge clk);
        #1;
        dom_val[0] = a; dom_val[1] = b; dom_val[2] = c;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    initial begin
        dom_val[0] = 8'h5A; dom_val[1] = 8'hC3; dom_val[2] = 8'h0F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1: reset state
        check("R1 data0", drv_data[0], '0);
        check("R1 hiz", drv_hiz[0] | drv_hiz[1] | drv_hiz[2], '0);
        check("R1 pad", pad_val, '0);
        check("R1 minority", {5'b0, minority}, '0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R3: all eight domain patterns in one word
        put(8'b11110000, 8'b11001100, 8'b10101010);
        settle();
        check("R3 domain0 vector", drv_hiz[0], 8'b00011000);
        check("R3 domain1", drv_hiz[1], 8'b00100100);
        check("R3 domain2", drv_hiz[2], 8'b01000010);
        check("R7 majority", pad_val, 8'b11101000);

        // R4: full agreement on several words
        for (int i = 0; i < 20; i++) begin
            logic [W-1:0] v;
            v = W'($urandom);
            put(v, v, v);
            settle();
            check("R4 all enabled", drv_hiz[0] | drv_hiz[1] | drv_hiz[2], '0);
            check("R4 pad", pad_val, v);
        end

        // R5: single-domain faults, each domain in turn
        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] v;
            logic [W-1:0] m;
            int fd;
            v  = W'($urandom);
            m  = W'($urandom) | 8'h01;
            fd = i % 3;
            put(fd == 0 ? v ^ m : v, fd == 1 ? v ^ m : v, fd == 2 ? v ^ m : v);
            settle();
            check("R5 masked", pad_val, v);
            check("R5 faulty released", drv_hiz[fd], m);
        end

        // R7: double faults drive the pin to the wrong value
        for (int i = 0; i < 30; i++) begin
            logic [W-1:0] v;
            logic [W-1:0] m;
            int good;
            v    = W'($urandom);
            m    = W'($urandom) | 8'h80;
            good = i % 3;
            put(good == 0 ? v : v ^ m, good == 1 ? v : v ^ m, good == 2 ? v : v ^ m);
            settle();
            check("R7 double fault pin", pad_val, v ^ m);
            check("R3 correct domain released", drv_hiz[good], m);
        end

        // Independent random words, model compare each cycle
        for (int i = 0; i < 200; i++) put(W'($urandom), W'($urandom), W'($urandom));

        // R1: reset in mid-run clears again
        put(8'hFF, 8'h00, 8'hF0);
        @(posedge clk);
        #1 rst_n = 1'b0;
        settle();
        check("R1 mid reset data", drv_data[0] | drv_data[1] | drv_data[2], '0);
        check("R1 mid reset pad", pad_val, '0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule